// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block collects seven active-low interrupt request lines, numbered 1 to 7, and reduces them to a single encoded level and an interrupt-pending flag for the processor. Levels 1 to 6 are maskable and level-sensitive. A 3-bit priority threshold decides which of them may be presented. Software writes the threshold through a strobe, and every acknowledge reloads it. Level 7 cannot be masked. It is captured on the high-to-low transition of its line into a sticky flag, which has its own output so that the non-maskable path reaches the processor separately.

When the processor services an interrupt it pulses the acknowledge input with the level it took. This clears the level-7 flag when that level is 7, and it raises the current priority threshold to the acknowledged level. All request lines pass through a two-flop synchronizer, and all outputs are registered.

Top module: `irq_level_ctrl`

## Requirements
- R1: After a synchronous reset, `pend_level` is 0, `irq_pend` is 0 and `nmi_pend` is 0. The threshold is 7, so asserted requests on levels 1 to 6 are not presented.
- R2: `req_n[N-1]` low (active) requests level N. A maskable level N (1 to 6) is presented only when N is strictly greater than the threshold. `pend_level` carries N in binary and `irq_pend` is 1 whenever `pend_level` is non-zero. A change on a maskable line reaches the outputs on the third rising edge after the change.
- R3: When several levels are presentable at once, the highest-numbered one is encoded.
- R4: A falling edge on `req_n[6]` presents level 7 and sets `nmi_pend` whatever the threshold, including a threshold of 7.
- R5: Level 7 stays pending after its line returns high, until it is acknowledged.
- R6: An acknowledge with `ack_level` = 7 clears the level-7 flag. An acknowledge with any other level leaves it set.
- R7: A new level-7 falling edge that arrives in the same cycle as a level-7 acknowledge leaves level 7 pending. The set takes precedence over the clear.
- R8: An acknowledge loads the threshold with `ack_level`. When `ack` and `mask_wr` coincide, the acknowledge wins.
- R9: Levels 1 to 6 follow their lines and drop out once the line is released. Holding the level-7 line low without a new edge does not re-raise level 7 after it has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 7 | Active-low requests; bit i is level i+1 |
| mask_wr | input | 1 | Threshold write strobe |
| mask_din | input | 3 | Threshold value to write |
| ack | input | 1 | Interrupt acknowledge pulse |
| ack_level | input | 3 | Level being acknowledged |
| pend_level | output | 3 | Encoded highest presented level, 0 when none |
| irq_pend | output | 1 | Any level presented |
| nmi_pend | output | 1 | Level-7 sticky flag |

## Verification
Two operations can land on the level-7 flag in the same cycle: a fresh falling edge can set it while a level-7 acknowledge clears it. The bench sets the flag first, then drives the line low again and places the acknowledge on the exact edge where the synchronized edge is seen. After that, level 7 must still be pending and `nmi_pend` must still be high. The threshold register has a similar collision, a software write together with an acknowledge. The bench judges which one won by checking whether a level-3 request is still presented.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned DEF_LVL_W  = 3;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '1;
        else     stg[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '1;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch #(
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_act,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_level,
  output logic             nmi_edge,
  output logic             nmi_flag
);
  logic req_d;
  logic clr;

  assign nmi_edge = req_act & ~req_d;
  assign clr      = ack && (ack_level == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      nmi_flag <= 1'b0;
    end else begin
      req_d <= req_act;
      if (nmi_edge)  nmi_flag <= 1'b1;
      else if (clr)  nmi_flag <= 1'b0;
    end
  end

  assert_nmi_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    nmi_flag && !clr |=> nmi_flag);
  assert_nmi_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr && !nmi_edge |=> !nmi_flag);
  assert_nmi_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    nmi_edge |=> nmi_flag);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned LVL_W = 3,
  localparam int unsigned NUM  = (1 << LVL_W) - 1
) (
  input  logic [NUM-1:0]   lvl_req,
  input  logic [LVL_W-1:0] mask,
  output logic [LVL_W-1:0] lvl_out
);
  logic [NUM-1:0] present;
  logic [NUM-1:0] grant;

  for (genvar i = 0; i < NUM; i++) begin : g_lvl
    if (i == NUM-1) begin : g_top
      assign present[i] = lvl_req[i];
      assign grant[i]   = present[i];
    end else begin : g_mask
      assign present[i] = lvl_req[i] && (LVL_W'(i+1) > mask);
      assign grant[i]   = present[i] && !(|present[NUM-1:i+1]);
    end
  end

  always_comb begin
    lvl_out = '0;
    for (int k = 0; k < NUM; k++)
      if (grant[k]) lvl_out = lvl_out | LVL_W'(k+1);
  end

  always_comb begin
    assert_grant_onehot_R3: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int unsigned LVL_W  = irq_lvl_pkg::DEF_LVL_W,
  parameter int unsigned STAGES = irq_lvl_pkg::DEF_STAGES,
  localparam int unsigned NUM   = (1 << LVL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NUM-1:0]   req_n,
  input  logic             mask_wr,
  input  logic [LVL_W-1:0] mask_din,
  input  logic             ack,
  input  logic [LVL_W-1:0] ack_level,
  output logic [LVL_W-1:0] pend_level,
  output logic             irq_pend,
  output logic             nmi_pend
);
  logic [NUM-1:0]   sync_q;
  logic [NUM-1:0]   req_act;
  logic [NUM-1:0]   enc_in;
  logic [LVL_W-1:0] mask_q;
  logic [LVL_W-1:0] enc_lvl;
  logic             nmi_edge;
  logic             nmi_flag;

  irq_sync #(.WIDTH(NUM), .STAGES(STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(req_n), .dout(sync_q)
  );

  assign req_act = ~sync_q;

  nmi_edge_latch #(.LVL_W(LVL_W)) nmi_i (
    .clk(clk), .rst(rst), .req_act(req_act[NUM-1]),
    .ack(ack), .ack_level(ack_level),
    .nmi_edge(nmi_edge), .nmi_flag(nmi_flag)
  );

  assign enc_in = {nmi_flag | nmi_edge, req_act[NUM-2:0]};

  irq_prio_enc #(.LVL_W(LVL_W)) enc_i (
    .lvl_req(enc_in), .mask(mask_q), .lvl_out(enc_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '1;
    else if (ack)     mask_q <= ack_level;
    else if (mask_wr) mask_q <= mask_din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_level <= '0;
      irq_pend   <= 1'b0;
    end else begin
      pend_level <= enc_lvl;
      irq_pend   <= (enc_lvl != '0);
    end
  end

  assign nmi_pend = nmi_flag;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (mask_q == '1) && (pend_level == '0) && !irq_pend && !nmi_pend);
  assert_threshold_R2: assert property (@(posedge clk) disable iff (rst)
    irq_pend && (pend_level != '1) |-> pend_level > $past(mask_q));
  assert_nmi_unmasked_R4: assert property (@(posedge clk) disable iff (rst)
    nmi_flag |=> pend_level == '1);
  assert_ack_loads_R8: assert property (@(posedge clk) disable iff (rst)
    ack |=> mask_q == $past(ack_level));
endmodule

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] req_n = 7'h7F;
  logic       mask_wr = 1'b0;
  logic [2:0] mask_din = '0;
  logic       ack = 1'b0;
  logic [2:0] ack_level = '0;
  logic [2:0] pend_level;
  logic       irq_pend;
  logic       nmi_pend;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_ctrl dut_i (
    .clk(clk), .rst(rst), .req_n(req_n), .mask_wr(mask_wr),
    .mask_din(mask_din), .ack(ack), .ack_level(ack_level),
    .pend_level(pend_level), .irq_pend(irq_pend), .nmi_pend(nmi_pend)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [2:0] exp_lvl, input logic exp_nmi);
    checks++;
    if (pend_level !== exp_lvl || irq_pend !== (exp_lvl != 0) || nmi_pend !== exp_nmi) begin
      fails++;
      $display("FAIL %s: got lvl=%0d pend=%0b nmi=%0b, expected lvl=%0d pend=%0b nmi=%0b",
               tag, pend_level, irq_pend, nmi_pend, exp_lvl, exp_lvl != 0, exp_nmi);
    end
  endtask

  task automatic write_mask(input logic [2:0] m);
    mask_wr = 1'b1; mask_din = m;
    tick(1);
    mask_wr = 1'b0;
  endtask

  task automatic do_ack(input logic [2:0] l);
    ack = 1'b1; ack_level = l;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got hang, expected completion");
    report();
  end

  initial begin
    // R1: maskable lines asserted during and after reset stay blocked
    req_n = 7'b1000000;
    tick(3);
    rst = 1'b0;
    tick(4);
    chk("R1", 3'd0, 1'b0);
    req_n = 7'h7F;
    tick(3);

    // R2 / R3: sweep every threshold against every maskable pattern
    for (int m = 0; m < 8; m++) begin
      write_mask(m[2:0]);
      for (int p = 0; p < 64; p++) begin
        logic [2:0] e;
        e = 0;
        for (int n = 1; n <= 6; n++)
          if (p[n-1] && n > m) e = n[2:0];
        req_n = {1'b1, ~p[5:0]};
        tick(3);
        chk(($countones(p) > 1) ? "R3" : "R2", e, 1'b0);
      end
    end
    req_n = 7'h7F;
    write_mask(3'd7);
    tick(3);

    // R4: level 7 edge with the threshold at 7
    req_n[6] = 1'b0;
    tick(3);
    chk("R4", 3'd7, 1'b1);
    // R5: sticky after release
    req_n[6] = 1'b1;
    tick(4);
    chk("R5", 3'd7, 1'b1);
    // R6: acknowledge of another level leaves level 7 set
    do_ack(3'd6);
    tick(1);
    chk("R6", 3'd7, 1'b1);
    do_ack(3'd7);
    tick(1);
    chk("R6", 3'd0, 1'b0);

    // R3: level 7 beats all maskable levels at threshold 0
    write_mask(3'd0);
    req_n = 7'b0000000;
    tick(3);
    chk("R3", 3'd7, 1'b1);
    do_ack(3'd7);
    req_n = 7'h7F;
    tick(3);
    chk("R6", 3'd0, 1'b0);

    // R7: new edge in the same cycle as a level-7 acknowledge
    req_n[6] = 1'b0;
    tick(3);
    req_n[6] = 1'b1;
    tick(3);
    req_n[6] = 1'b0;
    tick(2);
    ack = 1'b1; ack_level = 3'd7;
    tick(1);
    ack = 1'b0;
    tick(1);
    chk("R7", 3'd7, 1'b1);

    // R9: line held low, no new edge after acknowledge
    do_ack(3'd7);
    tick(2);
    chk("R9", 3'd0, 1'b0);
    req_n[6] = 1'b1;
    tick(3);

    // R9 / R2: level-sensitive maskable line and its latency
    write_mask(3'd0);
    req_n[4] = 1'b0;
    tick(2);
    chk("R2", 3'd0, 1'b0);
    tick(1);
    chk("R2", 3'd5, 1'b0);
    req_n[4] = 1'b1;
    tick(3);
    chk("R9", 3'd0, 1'b0);

    // R8: acknowledge beats a coincident software write
    req_n[2] = 1'b0;
    tick(3);
    chk("R8", 3'd3, 1'b0);
    ack = 1'b1; ack_level = 3'd2; mask_wr = 1'b1; mask_din = 3'd5;
    tick(1);
    ack = 1'b0; mask_wr = 1'b0;
    tick(1);
    chk("R8", 3'd3, 1'b0);
    write_mask(3'd5);
    tick(1);
    chk("R8", 3'd0, 1'b0);
    do_ack(3'd1);
    tick(1);
    chk("R8", 3'd3, 1'b0);

    report();
  end
endmodule